// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block is the target side of a one-wire debug link in the direction from target to host. It sends data to the host one bit at a time over a shared open-drain wire. The target never starts a bit. The host begins each bit by pulling the wire low. The target sees that falling edge through a synchronizer and then answers in one of two ways:

- **Logic 0:** the target holds the wire low for a fixed number of its own clock cycles. It then drives the wire high for one cycle to sharpen the rising edge, and releases it.
- **Logic 1:** the target never pulls the wire low. It only drives the one-cycle high speedup pulse, early enough that the wire is high well before the host samples it.

A word of `DATA_W` bits is handed over on a valid/ready port. It is sent most significant bit first, one bit for each host edge. `done` pulses once when the last bit has finished. Host edges are ignored when no word is loaded and while a bit is in progress.

Top module: `dbg_wire_tx`

## Requirements
- R1: After a synchronous reset, `drv_en`, `drv_val`, `busy` and `done` are 0, and `load_ready` is 1.
- R2: When `load_valid` and `load_ready` are both 1 on a clock edge, the word is captured. From the next cycle `busy` is 1 and `load_ready` is 0, and `load_ready` never equals 1 while `busy` is 1.
- R3: A `load_valid` raised while `busy` is 1 is not accepted: the bits then sent are those of the word already held.
- R4: Bits leave most significant bit first, exactly one for each host falling edge. After `DATA_W` bits the block is idle again.
- R5: For a 0 bit, `drv_en`=1 with `drv_val`=0 starts on the clock edge SYNC_STAGES+1 edges after the host pulls the wire low (3 with defaults). It lasts exactly LOW_HOLD (13) consecutive cycles, so the wire is still low when the host samples 10 cycles after its edge.
- R6: For a 1 bit, the block never drives the wire low.
- R7: Every bit ends with exactly one cycle of `drv_en`=1, `drv_val`=1, after which `drv_en` returns to 0. For a 0 bit this pulse directly follows the low hold. For a 1 bit it begins ONE_KICK_AT (7) cycles after the perceived start of the bit.
- R8: A host falling edge while nothing is loaded is ignored: `drv_en` stays 0 and `busy` stays 0.
- R9: A host falling edge during a bit in progress is ignored. That bit's drive timing is unchanged, and no extra bit is consumed.
- R10: `done` is a one-cycle pulse on the edge at which the last bit's speedup pulse ends. `busy` falls and `load_ready` rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Word offered for sending |
| load_ready | output | 1 | Block can accept a word |
| load_data | input | DATA_W | Word to send, MSB first |
| line_in | input | 1 | Raw level of the shared wire |
| drv_en | output | 1 | Wire driver enable (0 = released) |
| drv_val | output | 1 | Level driven when enabled |
| busy | output | 1 | A word is loaded and not yet finished |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The case that is hardest to reach is a second host falling edge that arrives while a bit is still in progress. To produce it, the bench's host model releases the wire during a 1 bit and then pulls it low again before the speedup pulse. The bench then checks that the pulse position, the count of low cycles and the number of bits consumed are all unchanged. Random words with random gaps between bits cover the ordering, and directed all-zero and all-one words cover the two timing extremes.

// File: rtl/dbg_tx_pkg.sv
package dbg_tx_pkg;
  typedef enum logic [1:0] {
    TM_IDLE,
    TM_HOLD,
    TM_KICK
  } tm_state_t;
endpackage

// File: rtl/dbg_line_sync.sv
module dbg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  input  logic mask,
  output logic fall
);
  logic [STAGES-1:0] stg;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= '1;
      prev <= 1'b1;
    end else begin
      stg  <= {stg[STAGES-2:0], line_raw};
      prev <= stg[STAGES-1];
    end
  end

  // a falling edge counts only while the target is not driving
  assign fall = prev & ~stg[STAGES-1] & ~mask;
endmodule

// File: rtl/dbg_shift_reg.sv
module dbg_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         shift,
  output logic         msb,
  output logic         last
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= data;
      left <= CW'(W);
    end else if (shift) begin
      sreg <= {sreg[W-2:0], 1'b0};
      left <= left - CW'(1);
    end
  end

  assign msb  = sreg[W-1];
  assign last = (left == CW'(1));
endmodule

// File: rtl/dbg_bit_timer.sv
module dbg_bit_timer
  import dbg_tx_pkg::*;
#(
  parameter int LOW_HOLD    = 13,
  parameter int ONE_KICK_AT = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bit_val,
  output logic drv_en,
  output logic drv_val,
  output logic bit_end
);
  localparam int MAX_AT = (LOW_HOLD > ONE_KICK_AT) ? LOW_HOLD : ONE_KICK_AT;
  localparam int CNT_W  = $clog2(MAX_AT + 1);

  tm_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             cur_bit;
  logic [CNT_W-1:0] kick_at;

  assign kick_at = cur_bit ? CNT_W'(ONE_KICK_AT) : CNT_W'(LOW_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TM_IDLE;
      cnt     <= '0;
      cur_bit <= 1'b0;
      drv_en  <= 1'b0;
      drv_val <= 1'b0;
    end else begin
      unique case (state)
        TM_IDLE: begin
          if (start) begin
            state   <= TM_HOLD;
            cnt     <= CNT_W'(1);
            cur_bit <= bit_val;
            drv_en  <= ~bit_val;
            drv_val <= 1'b0;
          end
        end
        TM_HOLD: begin
          if (cnt == kick_at) begin
            state   <= TM_KICK;
            drv_en  <= 1'b1;
            drv_val <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        TM_KICK: begin
          state   <= TM_IDLE;
          drv_en  <= 1'b0;
          drv_val <= 1'b0;
        end
        default: state <= TM_IDLE;
      endcase
    end
  end

  assign bit_end = (state == TM_KICK);
endmodule

// File: rtl/dbg_wire_tx.sv
module dbg_wire_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_HOLD    = 13,
  parameter int ONE_KICK_AT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [DATA_W-1:0] load_data,
  input  logic              line_in,
  output logic              drv_en,
  output logic              drv_val,
  output logic              busy,
  output logic              done
);
  logic fall, msb, last, bit_end, waiting, load_fire, start;

  assign load_fire = load_valid & load_ready;
  assign start     = waiting & fall;

  dbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_raw(line_in), .mask(drv_en), .fall(fall)
  );

  dbg_shift_reg #(.W(DATA_W)) u_sreg (
    .clk(clk), .rst(rst), .load(load_fire), .data(load_data),
    .shift(bit_end), .msb(msb), .last(last)
  );

  dbg_bit_timer #(.LOW_HOLD(LOW_HOLD), .ONE_KICK_AT(ONE_KICK_AT)) u_timer (
    .clk(clk), .rst(rst), .start(start), .bit_val(msb),
    .drv_en(drv_en), .drv_val(drv_val), .bit_end(bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_ready <= 1'b1;
      busy       <= 1'b0;
      done       <= 1'b0;
      waiting    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_fire) begin
        load_ready <= 1'b0;
        busy       <= 1'b1;
        waiting    <= 1'b1;
      end else if (start) begin
        waiting <= 1'b0;
      end else if (bit_end) begin
        if (last) begin
          busy       <= 1'b0;
          load_ready <= 1'b1;
          done       <= 1'b1;
        end else begin
          waiting <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_wire_tx_chk.sv
module dbg_wire_tx_chk (
  input logic clk,
  input logic rst,
  input logic drv_en,
  input logic drv_val,
  input logic busy,
  input logic done,
  input logic load_ready
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!drv_en && !drv_val && !busy && !done && load_ready));

  assert_ready_excl_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !(load_ready && busy));

  assert_low_hold_start_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(drv_en) && !drv_val) |=> (drv_en && !drv_val));

  assert_kick_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (drv_en && drv_val) |=> !drv_en);

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !drv_en);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && !$past(done)));
endmodule

bind dbg_wire_tx dbg_wire_tx_chk u_chk (
  .clk(clk), .rst(rst), .drv_en(drv_en), .drv_val(drv_val),
  .busy(busy), .done(done), .load_ready(load_ready)
);

// File: tb/test_dbg_wire_tx.sv
module test_dbg_wire_tx;
  localparam int W     = 8;
  localparam int SYNC  = 2;
  localparam int HOLD  = 13;
  localparam int KICK1 = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_valid = 1'b0;
  logic [W-1:0] load_data = '0;
  logic load_ready, drv_en, drv_val, busy, done;
  logic host_low = 1'b0;
  logic wire_lvl;

  int checks = 0;
  int errors = 0;

  assign wire_lvl = (host_low || (drv_en && !drv_val)) ? 1'b0 : 1'b1;

  always #5 clk = ~clk;

  dbg_wire_tx #(.DATA_W(W), .SYNC_STAGES(SYNC), .LOW_HOLD(HOLD), .ONE_KICK_AT(KICK1)) i_dbg_wire_tx (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_ready(load_ready),
    .load_data(load_data), .line_in(wire_lvl), .drv_en(drv_en),
    .drv_val(drv_val), .busy(busy), .done(done)
  );

  function automatic int exp_kick_idx(input logic b);
    return SYNC + 1 + (b ? KICK1 : HOLD);
  endfunction
  function automatic int exp_first_en(input logic b);
    return b ? exp_kick_idx(b) : SYNC + 1;
  endfunction
  function automatic int exp_low(input logic b);
    return b ? 0 : HOLD;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [W-1:0] d);
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = d;
    @(negedge clk);
    load_valid = 1'b0;
    check(busy && !load_ready, "R2 accept", {busy, load_ready}, 2);
  endtask

  // host pulls low at index 0; optional second edge inside the bit (R9)
  task automatic run_bit(input logic b, input logic last_bit, input logic glitch);
    int first_en = -1, lows = 0, kicks = 0, kick_idx = -1, done_n = 0, done_idx = -1;
    logic samp = 1'b0;
    @(negedge clk);
    host_low = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (i == 4) host_low = 1'b0;
      if (glitch && i == 6) host_low = 1'b1;
      if (glitch && i == 8) host_low = 1'b0;
      if (drv_en && first_en < 0) first_en = i;
      if (drv_en && !drv_val) lows++;
      if (drv_en && drv_val) begin kicks++; kick_idx = i; end
      if (done) begin done_n++; done_idx = i; end
      if (i == 10) samp = wire_lvl;
    end
    check(first_en == exp_first_en(b), "R5 drive start", first_en, exp_first_en(b));
    if (b) check(lows == 0, "R6 no low drive", lows, 0);
    else   check(lows == exp_low(b), "R5 low hold length", lows, exp_low(b));
    check(kicks == 1, "R7 one speedup cycle", kicks, 1);
    check(kick_idx == exp_kick_idx(b), "R7 speedup position", kick_idx, exp_kick_idx(b));
    check(samp == b, "R4 host sample MSB first", samp, b);
    check(!drv_en, "R7 released after bit", drv_en, 0);
    if (last_bit) begin
      check(done_n == 1 && done_idx == exp_kick_idx(b) + 1, "R10 done pulse", done_idx, exp_kick_idx(b) + 1);
      check(!busy && load_ready, "R10 idle after word", {busy, load_ready}, 1);
    end else begin
      check(done_n == 0 && busy, "R4 word continues", done_n, 0);
    end
    if (glitch) check(kick_idx == exp_kick_idx(b), "R9 edge in bit ignored", kick_idx, exp_kick_idx(b));
  endtask

  task automatic send_word(input logic [W-1:0] d, input int glitch_bit);
    for (int k = W - 1; k >= 0; k--) begin
      run_bit(d[k], k == 0, (k == glitch_bit) && d[k]);
      repeat ($urandom_range(0, 4)) @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen_drive;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!drv_en && !drv_val && !busy && !done && load_ready, "R1 reset state",
          {drv_en, drv_val, busy, done, load_ready}, 1);

    // R8: host edge with nothing loaded
    seen_drive = 0;
    host_low = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 4) host_low = 1'b0;
      if (drv_en || busy) seen_drive++;
    end
    check(seen_drive == 0, "R8 idle edge ignored", seen_drive, 0);

    // R3: load attempt while busy, then a glitch inside a 1 bit (R9)
    load_word(8'hA5);
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = 8'h3C;
    @(negedge clk);
    @(negedge clk);
    load_valid = 1'b0;
    check(busy && !load_ready, "R3 busy load refused", load_ready, 0);
    send_word(8'hA5, 5);

    load_word(8'h00);
    send_word(8'h00, -1);
    load_word(8'hFF);
    send_word(8'hFF, 3);

    for (int n = 0; n < 4; n++) begin
      logic [W-1:0] d;
      d = W'($urandom);
      load_word(d);
      send_word(d, -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule